// File: doc/BRIEF.md
# Use-Bit Pseudo-LRU Victim Selector

This unit picks which way of a set-associative cache to evict. Each set holds one use bit per way. Whenever a way of a set is touched, whether by a hit or by a refill that fills the chosen victim, the bit for that way is set. If setting it would leave every bit of the set at one, the set is reduced to the newly touched way alone. Over time the clear bits mark ways that have not been used recently, and a victim is always taken from among them.

When several ways are clear, a 16-bit linear feedback shift register breaks the tie. The register starts from a fixed seed at reset, so a given access trace always produces the same victims. The victim output is combinational from the addressed set's bits and the register's current value. The register moves one step on each cycle that carries an eviction request. Tag storage, data storage and hit detection sit outside the unit. The caller reports a refill as an ordinary touch of the victim way.

Top module: `plru_use_bits`

## Requirements
- R1: After reset every use bit of every set is zero, and the shift register holds the seed 16'hACE1, so the first victim of any set is way 1.
- R2: A cycle with `touch` high sets the use bit of `touch_way` in set `set_idx` at that clock edge. Other sets are not changed.
- R3: If a touch would make all use bits of the set one, the set is left holding only the touched way's bit.
- R4: `evict_way` always names a way whose use bit in set `set_idx` is currently zero.
- R5: The shift register shifts left by one with feedback bit0 = q15 ^ q13 ^ q12 ^ q10 on each clock edge where `evict_req` is high. It holds its value on every other edge.
- R6: The search starts at the way numbered by register bits [1:0] and proceeds upward with wrap-around. The first way whose bit is zero is the victim.
- R7: A cycle with `touch` low leaves all use bits unchanged.
- R8: Each set keeps its own bits. Touching one set never alters the victim of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch | input | 1 | Marks a hit or refill in this cycle |
| set_idx | input | 6 | Set addressed by the touch and by the victim lookup |
| touch_way | input | 2 | Way that was hit or refilled |
| evict_req | input | 1 | Victim requested this cycle; steps the shift register |
| evict_way | output | 2 | Chosen victim way for `set_idx` |

## Verification
The bench builds the unit with its defaults: 4 ways and 64 sets. With these values, two register bits select the starting way, so every rotation of the search can be reached within a few requests. The top set index, 63, can be addressed directly. Three distinct touches on a fresh set leave exactly one clear way, so the victim becomes independent of the register. A fourth touch drives the set into saturation, and the bench then observes the reduced state through the victim output.

// File: rtl/plru_use_bits.sv
module plru_use_bits #(
  parameter int          WAYS      = 4,
  parameter int          SETS      = 64,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      touch,
  input  logic [$clog2(SETS)-1:0]   set_idx,
  input  logic [$clog2(WAYS)-1:0]   touch_way,
  input  logic                      evict_req,
  output logic [$clog2(WAYS)-1:0]   evict_way
);
  localparam int WW = $clog2(WAYS);

  logic [WAYS-1:0] bits_q [SETS];
  logic [WAYS-1:0] row, hit_oh, merged, row_nxt;
  logic [15:0]     lfsr_q;
  logic [WW-1:0]   start;
  logic            found;

  assign row     = bits_q[set_idx];
  assign hit_oh  = WAYS'(1) << touch_way;
  assign merged  = row | hit_oh;
  assign row_nxt = (&merged) ? hit_oh : merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
    end else if (touch) begin
      bits_q[set_idx] <= row_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         lfsr_q <= LFSR_SEED;
    else if (evict_req) lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  assign start = lfsr_q[WW-1:0];

  always_comb begin
    evict_way = start;
    found     = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !row[WW'((int'(start) + i) % WAYS)]) begin
        evict_way = WW'((int'(start) + i) % WAYS);
        found     = 1'b1;
      end
    end
  end
endmodule

module plru_use_bits_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    touch,
  input logic [$clog2(SETS)-1:0] set_idx,
  input logic [$clog2(WAYS)-1:0] touch_way,
  input logic                    evict_req,
  input logic [$clog2(WAYS)-1:0] evict_way,
  input logic [WAYS-1:0]         row,
  input logic [15:0]             lfsr
);
  // R4
  victim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !row[evict_way]);
  // R3
  never_full_chk: assert property (@(posedge clk) disable iff (!rst_n) row != {WAYS{1'b1}});
  // R5
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !evict_req |=> $stable(lfsr));
  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0);
  // R2
  touch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (set_idx != $past(set_idx)) || row[$past(touch_way)]);
endmodule

bind plru_use_bits plru_use_bits_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .touch(touch), .set_idx(set_idx), .touch_way(touch_way),
  .evict_req(evict_req), .evict_way(evict_way), .row(row), .lfsr(lfsr_q)
);

// File: tb/sim_plru_use_bits.sv
`timescale 1ns/1ps
module sim_plru_use_bits;
  logic       clk = 0, rst_n = 0, touch = 0, evict_req = 0;
  logic [5:0] set_idx = '0;
  logic [1:0] touch_way = '0;
  logic [1:0] evict_way;
  logic [15:0] m_lfsr = 16'hACE1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  plru_use_bits u0 (.clk(clk), .rst_n(rst_n), .touch(touch), .set_idx(set_idx),
    .touch_way(touch_way), .evict_req(evict_req), .evict_way(evict_way));

  // {set, way a, way b, way c, expected victim}
  localparam logic [13:0] VEC [8] = '{
    {6'd1,  2'd0, 2'd1, 2'd2, 2'd3},
    {6'd2,  2'd3, 2'd2, 2'd1, 2'd0},
    {6'd3,  2'd1, 2'd3, 2'd0, 2'd2},
    {6'd4,  2'd0, 2'd2, 2'd3, 2'd1},
    {6'd5,  2'd2, 2'd0, 2'd1, 2'd3},
    {6'd6,  2'd3, 2'd1, 2'd0, 2'd2},
    {6'd9,  2'd2, 2'd3, 2'd0, 2'd1},
    {6'd10, 2'd1, 2'd0, 2'd3, 2'd2}
  };

  function automatic logic [1:0] pick(input logic [3:0] b, input logic [15:0] l);
    for (int i = 0; i < 4; i++) begin
      if (!b[(l[1:0] + i) % 4]) return 2'((l[1:0] + i) % 4);
    end
    return l[1:0];
  endfunction

  task automatic do_touch(input logic [5:0] s, input logic [1:0] w);
    @(negedge clk);
    touch = 1; evict_req = 0; set_idx = s; touch_way = w;
  endtask

  task automatic do_idle_touch(input logic [5:0] s, input logic [1:0] w);
    @(negedge clk);
    touch = 0; evict_req = 0; set_idx = s; touch_way = w;
  endtask

  task automatic chk_vic(input logic [5:0] s, input logic [1:0] exp, input bit adv, input string req);
    @(negedge clk);
    touch = 0; evict_req = adv; set_idx = s;
    #2;
    checks++;
    if (evict_way !== exp) begin
      errors++;
      $display("FAIL %s set %0d: actual %0d expected %0d", req, s, evict_way, exp);
    end
    if (adv) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, first victim is way 1; R5 no step without request
    chk_vic(6'd0,  2'd1, 0, "R1");
    chk_vic(6'd63, 2'd1, 0, "R1");
    chk_vic(6'd63, 2'd1, 0, "R5");

    // R2 table of three distinct touches leaving a single clear way
    foreach (VEC[k]) begin
      do_touch(VEC[k][13:8], VEC[k][7:6]);
      do_touch(VEC[k][13:8], VEC[k][5:4]);
      do_touch(VEC[k][13:8], VEC[k][3:2]);
      chk_vic(VEC[k][13:8], VEC[k][1:0], 1, "R2");
    end

    // R8 untouched set and earlier set unaffected by later traffic
    chk_vic(6'd11, pick(4'b0000, m_lfsr), 0, "R8");
    chk_vic(6'd1, 2'd3, 0, "R8");

    // R7 touch strobe low: way 3 of set 1 would saturate it
    do_idle_touch(6'd1, 2'd3);
    chk_vic(6'd1, 2'd3, 0, "R7");

    // R3 saturation keeps only the newest way
    do_touch(6'd20, 2'd0);
    do_touch(6'd20, 2'd1);
    do_touch(6'd20, 2'd2);
    do_touch(6'd20, 2'd3);
    chk_vic(6'd20, pick(4'b1000, m_lfsr), 0, "R3");
    do_touch(6'd20, 2'd0);
    do_touch(6'd20, 2'd1);
    chk_vic(6'd20, 2'd2, 1, "R3");

    // R5 register steps once per request on a fresh set
    for (int n = 0; n < 6; n++) chk_vic(6'd30, m_lfsr[1:0], 1, "R5");
    chk_vic(6'd30, m_lfsr[1:0], 0, "R5");
    chk_vic(6'd30, m_lfsr[1:0], 0, "R5");

    // R6 scan with wrap over ways 2 and 3 clear
    do_touch(6'd31, 2'd0);
    do_touch(6'd31, 2'd1);
    for (int n = 0; n < 6; n++) chk_vic(6'd31, pick(4'b0011, m_lfsr), 1, "R6");

    // R4 refill of the victim then only one clear way remains
    do_touch(6'd31, 2'd2);
    chk_vic(6'd31, 2'd3, 1, "R4");
    do_touch(6'd31, 2'd3);
    chk_vic(6'd31, pick(4'b1000, m_lfsr), 1, "R3");

    @(negedge clk);
    touch = 0; evict_req = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule